// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block is the datapath piece between a 64-bit integer register file and a data memory port that is eight bytes wide. A request carries an access code, the low bits of the byte address, a byte-order select, an architecture-level select and the register value to be stored. The memory word read at that address is also presented, in the same cycle. One clock later the block returns four things. For a store, it returns the lane write enables and the store bytes placed in their lanes. For a load, it returns the extracted value, widened to 64 bits. It also raises a misalignment flag or a reserved-operation flag when either applies.

The byte-order select mirrors the lane mapping while the block runs, so one instance can serve both byte orders. The lowest byte address of an object always names the object. In little-endian order that byte holds the least significant byte. In big-endian order it holds the most significant byte. The architecture-level select has two settings. With the narrow (32-bit) subset selected, the 64-bit-only operations are refused. With the full level selected, they execute. An access that is not naturally aligned is never split into parts. It is refused and flagged.

Top module: `mem_lane_align`

## Requirements
- R1: While reset is held, and until the first request is accepted, `valid_o`, `be_o`, `err_o`, `rsvd_o`, `wr_data_o` and `ld_data_o` are all zero.
- R2: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high. In any cycle where `valid_o` is low, `be_o`, `err_o` and `rsvd_o` are zero.
- R3: The access codes on `op_i` are: 0 signed byte load, 1 unsigned byte load, 2 signed halfword load, 3 unsigned halfword load, 4 signed word load, 5 unsigned word load, 6 doubleword load, 8 byte store, 9 halfword store, 10 word store and 11 doubleword store. An accepted store enables exactly as many lanes as its size (1, 2, 4 or 8). A load enables no lane.
- R4: With `big_i`=0, memory byte address `a` maps to lane `a`. Byte k of the object (k=0 is the least significant byte) sits at address `addr_i`+k. This holds for both the write lanes and the read lanes.
- R5: With `big_i`=1, memory byte address `a` maps to lane 7-`a`. The byte at `addr_i` is the most significant byte of the object. Lanes of a store that are not enabled carry zero on `wr_data_o`.
- R6: Signed loads (codes 0, 2 and 4) copy the top bit of the loaded object into every higher bit of `ld_data_o`.
- R7: Unsigned loads (codes 1, 3 and 5) fill every bit of `ld_data_o` above the object with zero. A doubleword load returns all 64 bits unchanged.
- R8: A legal access whose address is not a multiple of its size raises `err_o`. It enables no lane, and `ld_data_o` and `wr_data_o` are zero for it.
- R9: With `wide64_i`=0, codes 5, 6 and 11 raise `rsvd_o` and not `err_o`, whatever the address. With `wide64_i`=1 they execute, and the other codes behave the same in both settings.
- R10: Codes 7 and 12 to 15 always raise `rsvd_o`. No request ever raises `err_o` and `rsvd_o` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Access code (see R3) |
| addr_i | input | 3 | Byte offset of the access within the 8-byte memory word |
| big_i | input | 1 | 1 selects big-endian lane order, 0 little-endian |
| wide64_i | input | 1 | 1 selects the 64-bit architecture level, 0 the 32-bit subset |
| st_data_i | input | 64 | Register value to store; its low-order bytes are used |
| mem_rdata_i | input | 64 | Memory word read at the access address, lanes 0..7 |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| be_o | output | 8 | Per-lane write enables |
| wr_data_o | output | 64 | Store bytes placed in their lanes |
| ld_data_o | output | 64 | Extracted and extended load value |
| err_o | output | 1 | Misaligned access |
| rsvd_o | output | 1 | Operation reserved at the selected level, or unused code |

## Verification
The bound checker watches, on every cycle, the one-cycle strobe timing and the quiet outputs between requests. It also confirms that enables always come in power-of-two groups, that a raised flag blocks all writes and read data, that an odd halfword address always faults, and that the 64-bit-only codes are refused in the narrow subset. Whether the right lanes are chosen in each byte order, and whether the right bytes land in them or come back with the right extension, can only be shown by the bench. The bench sweeps every code, offset, byte order and level against a byte-addressed memory model of its own.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [3:0] {
      OP_LB  = 4'd0,
      OP_LBU = 4'd1,
      OP_LH  = 4'd2,
      OP_LHU = 4'd3,
      OP_LW  = 4'd4,
      OP_LWU = 4'd5,
      OP_LD  = 4'd6,
      OP_SB  = 4'd8,
      OP_SH  = 4'd9,
      OP_SW  = 4'd10,
      OP_SD  = 4'd11
   } lsu_op_e;

   typedef struct packed {
      logic [1:0] size_log2;
      logic       sext;
      logic       store;
      logic       rsvd;
   } lsu_dec_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
(
   input  logic [3:0] op_i,
   input  logic       wide64_i,
   output lsu_dec_t   dec_o
);

   always_comb begin
      dec_o = '{size_log2: 2'd0, sext: 1'b0, store: 1'b0, rsvd: 1'b0};
      case (lsu_op_e'(op_i))
         OP_LB:  dec_o.sext = 1'b1;
         OP_LBU: ;
         OP_LH:  begin dec_o.size_log2 = 2'd1; dec_o.sext = 1'b1; end
         OP_LHU: dec_o.size_log2 = 2'd1;
         OP_LW:  begin dec_o.size_log2 = 2'd2; dec_o.sext = 1'b1; end
         OP_LWU: begin dec_o.size_log2 = 2'd2; dec_o.rsvd = ~wide64_i; end
         OP_LD:  begin dec_o.size_log2 = 2'd3; dec_o.rsvd = ~wide64_i; end
         OP_SB:  dec_o.store = 1'b1;
         OP_SH:  begin dec_o.size_log2 = 2'd1; dec_o.store = 1'b1; end
         OP_SW:  begin dec_o.size_log2 = 2'd2; dec_o.store = 1'b1; end
         OP_SD:  begin
            dec_o.size_log2 = 2'd3;
            dec_o.store     = 1'b1;
            dec_o.rsvd      = ~wide64_i;
         end
         default: dec_o.rsvd = 1'b1;
      endcase
   end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
   parameter  int LANES  = 8,
   localparam int OFF_W  = $clog2(LANES),
   localparam int DATA_W = LANES * 8
) (
   input  logic [OFF_W-1:0]  off_i,
   input  logic [1:0]        size_log2_i,
   input  logic              big_i,
   input  logic [DATA_W-1:0] src_i,
   output logic [LANES-1:0]  be_o,
   output logic [DATA_W-1:0] data_o
);

   logic [OFF_W-1:0] mask;
   assign mask = OFF_W'((32'd1 << size_log2_i) - 32'd1);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [OFF_W-1:0] LANE = OFF_W'(l);
      logic [OFF_W-1:0] byte_addr;
      logic [OFF_W-1:0] pos;
      logic [OFF_W-1:0] src_byte;

      always_comb begin
         byte_addr = big_i ? ~LANE : LANE;
         pos       = (byte_addr - off_i) & mask;
         src_byte  = big_i ? (mask - pos) : pos;
      end

      assign be_o[l]          = ((byte_addr ^ off_i) & ~mask) == '0;
      assign data_o[8*l +: 8] = be_o[l] ? src_i[{src_byte, 3'b000} +: 8] : 8'h00;
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
   parameter  int LANES  = 8,
   localparam int OFF_W  = $clog2(LANES),
   localparam int DATA_W = LANES * 8
) (
   input  logic [OFF_W-1:0]  off_i,
   input  logic [1:0]        size_log2_i,
   input  logic              sext_i,
   input  logic              big_i,
   input  logic [DATA_W-1:0] mem_i,
   output logic [DATA_W-1:0] result_o
);

   logic [OFF_W-1:0]  mask;
   logic [DATA_W-1:0] raw;
   logic [LANES-1:0]  active;
   logic              sign;

   assign mask = OFF_W'((32'd1 << size_log2_i) - 32'd1);

   for (genvar k = 0; k < LANES; k++) begin : g_byte
      localparam logic [OFF_W-1:0] KB = OFF_W'(k);
      logic [OFF_W-1:0] byte_addr;
      logic [OFF_W-1:0] lane;

      always_comb begin
         byte_addr = off_i + (big_i ? (mask - KB) : KB);
         lane      = big_i ? ~byte_addr : byte_addr;
      end

      assign raw[8*k +: 8] = mem_i[{lane, 3'b000} +: 8];
      assign active[k]     = (32'(k) >> size_log2_i) == 32'd0;
   end

   assign sign = raw[{mask, 3'b111}];

   for (genvar k = 0; k < LANES; k++) begin : g_ext
      assign result_o[8*k +: 8] = active[k] ? raw[8*k +: 8] : {8{sext_i & sign}};
   end

endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
   import lsu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        valid_i,
   input  logic [3:0]                  op_i,
   input  logic [$clog2(DATA_W/8)-1:0] addr_i,
   input  logic                        big_i,
   input  logic                        wide64_i,
   input  logic [DATA_W-1:0]           st_data_i,
   input  logic [DATA_W-1:0]           mem_rdata_i,
   output logic                        valid_o,
   output logic [DATA_W/8-1:0]         be_o,
   output logic [DATA_W-1:0]           wr_data_o,
   output logic [DATA_W-1:0]           ld_data_o,
   output logic                        err_o,
   output logic                        rsvd_o
);

   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   if (DATA_W != 64) begin : g_bad_width
      $error("mem_lane_align: access codes cover exactly eight byte lanes");
   end

   lsu_dec_t          dec;
   logic [OFF_W-1:0]  size_mask;
   logic              misalign;
   logic              accept;
   logic [LANES-1:0]  lane_be;
   logic [DATA_W-1:0] lane_data;
   logic [DATA_W-1:0] load_val;

   lsu_decode u_decode (
      .op_i     (op_i),
      .wide64_i (wide64_i),
      .dec_o    (dec)
   );

   assign size_mask = OFF_W'((32'd1 << dec.size_log2) - 32'd1);
   assign misalign  = (addr_i & size_mask) != '0;
   assign accept    = ~dec.rsvd & ~misalign;

   lsu_store_lanes #(.LANES(LANES)) u_store (
      .off_i       (addr_i),
      .size_log2_i (dec.size_log2),
      .big_i       (big_i),
      .src_i       (st_data_i),
      .be_o        (lane_be),
      .data_o      (lane_data)
   );

   lsu_load_extract #(.LANES(LANES)) u_load (
      .off_i       (addr_i),
      .size_log2_i (dec.size_log2),
      .sext_i      (dec.sext),
      .big_i       (big_i),
      .mem_i       (mem_rdata_i),
      .result_o    (load_val)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o   <= 1'b0;
         be_o      <= '0;
         wr_data_o <= '0;
         ld_data_o <= '0;
         err_o     <= 1'b0;
         rsvd_o    <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            err_o     <= ~dec.rsvd & misalign;
            rsvd_o    <= dec.rsvd;
            be_o      <= (accept & dec.store) ? lane_be : '0;
            wr_data_o <= (accept & dec.store) ? lane_data : '0;
            ld_data_o <= (accept & ~dec.store) ? load_val : '0;
         end else begin
            err_o  <= 1'b0;
            rsvd_o <= 1'b0;
            be_o   <= '0;
         end
      end
   end

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
   parameter int DATA_W = 64
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                valid_i,
   input logic [3:0]          op_i,
   input logic                addr_lsb_i,
   input logic                wide64_i,
   input logic                valid_o,
   input logic [DATA_W/8-1:0] be_o,
   input logic [DATA_W-1:0]   ld_data_o,
   input logic                err_o,
   input logic                rsvd_o
);

   // R2
   valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (valid_o == $past(valid_i)));

   // R2
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> (be_o == '0 && !err_o && !rsvd_o));

   // R3
   be_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (be_o != '0) |-> ($countones(be_o) == 1 || $countones(be_o) == 2 ||
                        $countones(be_o) == 4 || $countones(be_o) == 8));

   // R8
   flag_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o || rsvd_o) |-> (be_o == '0 && ld_data_o == '0));

   // R8
   odd_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && addr_lsb_i &&
       (op_i == 4'(lsu_pkg::OP_SH) || op_i == 4'(lsu_pkg::OP_LH))) |=> err_o);

   // R9
   narrow_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !wide64_i &&
       (op_i == 4'(lsu_pkg::OP_LD) || op_i == 4'(lsu_pkg::OP_SD) ||
        op_i == 4'(lsu_pkg::OP_LWU))) |=> (rsvd_o && !err_o));

   // R10
   flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(err_o && rsvd_o));

endmodule

bind mem_lane_align lsu_align_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .valid_i    (valid_i),
   .op_i       (op_i),
   .addr_lsb_i (addr_i[0]),
   .wide64_i   (wide64_i),
   .valid_o    (valid_o),
   .be_o       (be_o),
   .ld_data_o  (ld_data_o),
   .err_o      (err_o),
   .rsvd_o     (rsvd_o)
);

// File: tb/mem_lane_align_tb.sv
`timescale 1ns/1ps
module mem_lane_align_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [2:0]  addr_i = '0;
   logic        big_i = 1'b0;
   logic        wide64_i = 1'b1;
   logic [63:0] st_data_i = '0;
   logic [63:0] mem_rdata_i = '0;
   logic        valid_o;
   logic [7:0]  be_o;
   logic [63:0] wr_data_o;
   logic [63:0] ld_data_o;
   logic        err_o;
   logic        rsvd_o;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] mem_b [8];

   always #4 clk = ~clk;

   mem_lane_align u_dut (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
      .addr_i(addr_i), .big_i(big_i), .wide64_i(wide64_i),
      .st_data_i(st_data_i), .mem_rdata_i(mem_rdata_i),
      .valid_o(valid_o), .be_o(be_o), .wr_data_o(wr_data_o),
      .ld_data_o(ld_data_o), .err_o(err_o), .rsvd_o(rsvd_o)
   );

   // {op, addr, big, wide, be, err, rsvd, requirement}
   localparam int NV = 14;
   localparam logic [22:0] VEC [NV] = '{
      {4'd8,  3'd3, 1'b0, 1'b1, 8'h08, 1'b0, 1'b0, 4'd4},
      {4'd8,  3'd3, 1'b1, 1'b1, 8'h10, 1'b0, 1'b0, 4'd5},
      {4'd9,  3'd2, 1'b0, 1'b1, 8'h0C, 1'b0, 1'b0, 4'd4},
      {4'd9,  3'd2, 1'b1, 1'b1, 8'h30, 1'b0, 1'b0, 4'd5},
      {4'd10, 3'd4, 1'b0, 1'b1, 8'hF0, 1'b0, 1'b0, 4'd3},
      {4'd10, 3'd4, 1'b1, 1'b1, 8'h0F, 1'b0, 1'b0, 4'd5},
      {4'd11, 3'd0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 4'd3},
      {4'd9,  3'd1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 4'd8},
      {4'd10, 3'd2, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 4'd8},
      {4'd11, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 4'd9},
      {4'd5,  3'd4, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 4'd9},
      {4'd12, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 4'd10},
      {4'd7,  3'd0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 4'd10},
      {4'd6,  3'd4, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 4'd8}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int op_size(input int o);
      case (o)
         0, 1, 8:  return 1;
         2, 3, 9:  return 2;
         4, 5, 10: return 4;
         default:  return 8;
      endcase
   endfunction

   task automatic request(input logic [3:0] o, input logic [2:0] a, input logic b,
                          input logic w, input logic [63:0] sd);
      @(negedge clk);
      op_i = o; addr_i = a; big_i = b; wide64_i = w; st_data_i = sd;
      for (int l = 0; l < 8; l++) mem_rdata_i[8*l +: 8] = mem_b[b ? 7 - l : l];
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) mem_b[i] = 8'h11 * 8'(i);
      // R1 reset values
      repeat (3) @(negedge clk);
      check("R1 valid_o", 64'(valid_o), 64'd0);
      check("R1 be_o", 64'(be_o), 64'd0);
      check("R1 flags", {62'd0, err_o, rsvd_o}, 64'd0);
      check("R1 data", wr_data_o | ld_data_o, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {55'd0, valid_o, be_o}, 64'd0);

      // table of directed lane/flag vectors
      for (int v = 0; v < NV; v++) begin
         request(VEC[v][22:19], VEC[v][18:16], VEC[v][15], VEC[v][14], 64'h0123456789ABCDEF);
         check($sformatf("R%0d be_o vec%0d", VEC[v][3:0], v), 64'(be_o), 64'(VEC[v][13:6]));
         check($sformatf("R%0d flags vec%0d", VEC[v][3:0], v),
               {62'd0, err_o, rsvd_o}, {62'd0, VEC[v][5], VEC[v][4]});
      end

      // R2: strobe lasts one cycle, enables drop when idle
      request(4'd11, 3'd0, 1'b0, 1'b1, 64'hFFFF_0000_FFFF_0000);
      check("R2 strobe", 64'(valid_o), 64'd1);
      @(negedge clk);
      check("R2 idle strobe", 64'(valid_o), 64'd0);
      check("R2 idle be", 64'(be_o), 64'd0);

      // R6/R7 directed sign cases, little-endian word at 4 with top bit set
      mem_b[4] = 8'h01; mem_b[5] = 8'h02; mem_b[6] = 8'h03; mem_b[7] = 8'h84;
      request(4'd4, 3'd4, 1'b0, 1'b1, 64'd0);
      check("R6 word sign", ld_data_o, 64'hFFFF_FFFF_8403_0201);
      request(4'd5, 3'd4, 1'b0, 1'b1, 64'd0);
      check("R7 word zero", ld_data_o, 64'h0000_0000_8403_0201);
      request(4'd4, 3'd4, 1'b1, 1'b1, 64'd0);
      check("R5 word big", ld_data_o, 64'h0000_0000_0102_0384);

      // sweep: every code, offset, byte order and level against the byte model
      for (int o = 0; o < 12; o++) begin
         if (o == 7) continue;
         for (int w = 0; w < 2; w++)
         for (int b = 0; b < 2; b++)
         for (int a = 0; a < 8; a++) begin
            int sz; bit st; bit sg; bit rs; bit mis;
            logic [63:0] sd; logic [63:0] exp_ld; logic [63:0] exp_wd; logic [7:0] exp_be;
            logic [7:0] nm [8]; bit tch [8]; int ad; string tag;
            for (int i = 0; i < 8; i++) mem_b[i] = 8'(i * 53 + o * 7 + a * 3 + b * 128);
            sd = 64'hF1E2_D3C4_B5A6_9788 ^ {8{8'(a * 17 + o)}};
            sz = op_size(o); st = (o >= 8); sg = (o == 0 || o == 2 || o == 4);
            rs = (w == 0) && (o == 5 || o == 6 || o == 11);
            mis = !rs && (a % sz != 0);
            exp_ld = '0; exp_wd = '0; exp_be = '0;
            for (int i = 0; i < 8; i++) begin nm[i] = mem_b[i]; tch[i] = 1'b0; end
            if (!rs && !mis) begin
               for (int k = 0; k < sz; k++) begin
                  ad = (b != 0) ? a + sz - 1 - k : a + k;
                  if (st) begin nm[ad] = sd[8*k +: 8]; tch[ad] = 1'b1; end
                  else exp_ld[8*k +: 8] = mem_b[ad];
               end
               if (!st && sz < 8 && sg && exp_ld[8*sz-1])
                  for (int k = sz; k < 8; k++) exp_ld[8*k +: 8] = 8'hFF;
               for (int l = 0; l < 8; l++) begin
                  ad = (b != 0) ? 7 - l : l;
                  exp_be[l] = tch[ad];
                  exp_wd[8*l +: 8] = tch[ad] ? nm[ad] : 8'h00;
               end
            end
            request(4'(o), 3'(a), b[0], w[0], sd);
            tag = (b != 0) ? "R5" : "R4";
            check($sformatf("R2 valid op%0d a%0d", o, a), 64'(valid_o), 64'd1);
            check($sformatf("R9 rsvd op%0d w%0d", o, w), 64'(rsvd_o), 64'(rs));
            check($sformatf("R8 err op%0d a%0d", o, a), 64'(err_o), 64'(mis));
            check($sformatf("%s R3 be op%0d a%0d", tag, o, a), 64'(be_o), 64'(exp_be));
            check($sformatf("%s wdata op%0d a%0d", tag, o, a), wr_data_o, exp_wd);
            check($sformatf("%s %s load op%0d a%0d", tag, sg ? "R6" : "R7", o, a),
                  ld_data_o, exp_ld);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule